// File: doc/BRIEF.md
# Read-Side Width-Matching Unpacker

The block sits between the 36-bit read interface of a show-ahead FIFO and an external read port. That port can run at 36, 18 or 9 bits. The write side of the FIFO is always 36 bits wide, and data flows only from the FIFO toward the read port. The block takes one stored word into a holding register. It then hands that word out as one, two or four pieces over successive accepted reads. It pops the next FIFO word only when the holding register is empty, or on the read that takes the final piece of the current word.

In the narrow modes, the order of the pieces follows an endian setting. Big-endian gives the most significant piece first, and little-endian gives the least significant piece first. The width code and the endian setting are captured once, on the first clock edge after reset is released. They stay fixed until the next reset. During that first cycle the block neither pops nor presents data.

Top module: `rd_unpacker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `rd_valid_o` and `fifo_pop_o` are 0, even when the FIFO holds data.
- R2: `width_sel_i` and `big_endian_i` are captured on the first rising clock edge after reset release. Later changes to them have no effect until the next reset.
- R3: Width code 00 selects 36-bit reads. Each accepted read returns the whole stored word on bits 35:0 and ends that word.
- R4: Width code 01 selects 18-bit reads. Each word takes two accepted reads, the piece appears on bits 17:0, and bits 35:18 are 0.
- R5: Width codes 10 and 11 select 9-bit reads. Each word takes four accepted reads, the piece appears on bits 8:0, and bits 35:9 are 0.
- R6: With `big_endian_i`=1 the pieces come out most significant first. In 18-bit mode that is word bits 35:18, then 17:0. In 9-bit mode it is 35:27, 26:18, 17:9, then 8:0.
- R7: With `big_endian_i`=0 the pieces come out least significant first, in the reverse of the R6 order.
- R8: `fifo_pop_o` is high only when `fifo_empty_i` is 0 and either no word is held or the current read takes the final piece. A word popped at a clock edge is presented with `rd_valid_o`=1 from that edge on. Every word written is delivered exactly once and in order.
- R9: A partly read word keeps `rd_valid_o`=1 and keeps its current piece on `rd_data_o` while the FIFO is empty and no read is made.
- R10: `rd_en_i` while `rd_valid_o`=0 has no effect: nothing is popped, and the next word still starts with its first piece.
- R11: When the final piece is read and the FIFO is not empty, the next word is presented in the following cycle with no idle cycle between.
- R12: `rd_data_o` is 0 whenever `rd_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| width_sel_i | input | 2 | Read width code: 00 = 36, 01 = 18, 1x = 9; captured after reset |
| big_endian_i | input | 1 | 1 = most significant piece first; captured after reset |
| fifo_data_i | input | 36 | Head word of the show-ahead FIFO |
| fifo_empty_i | input | 1 | FIFO holds no word |
| fifo_pop_o | output | 1 | Removes the head word at this clock edge |
| rd_en_i | input | 1 | Read request from the external port |
| rd_data_o | output | 36 | Current piece, zero-extended |
| rd_valid_o | output | 1 | A piece is available on `rd_data_o` |

## Verification
All four width codes are driven under both endian settings with random words, random read gaps and random FIFO underflow. A wrong lane pick, a swapped order or a missing upper-bit clear then shows up as a data mismatch in the mode concerned. Directed runs separate the pop timing cases: a prefilled FIFO at reset release shows the capture cycle. Continuous reads across three queued words show whether an idle cycle is inserted between words. A word left half-read while the FIFO is empty, after reads were requested against an empty block, shows whether the partial word is kept and whether spurious requests move the piece counter. Toggling the settings mid-run shows whether they are sampled only once.

// File: rtl/rd_unpacker_pkg.sv
package rd_unpacker_pkg;
  typedef enum logic [1:0] {
    WIDTH_FULL    = 2'b00,
    WIDTH_HALF    = 2'b01,
    WIDTH_QUARTER = 2'b10
  } width_e;

  function automatic width_e decode_width(logic [1:0] code);
    case (code)
      2'b00:   return WIDTH_FULL;
      2'b01:   return WIDTH_HALF;
      default: return WIDTH_QUARTER;
    endcase
  endfunction
endpackage

// File: rtl/rd_unpacker_cfg.sv
module rd_unpacker_cfg
  import rd_unpacker_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] width_sel_i,
  input  logic       big_endian_i,
  output logic       cfg_ok_o,
  output width_e     width_o,
  output logic       big_endian_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_ok_o     <= 1'b0;
      width_o      <= WIDTH_FULL;
      big_endian_o <= 1'b0;
    end else if (!cfg_ok_o) begin
      cfg_ok_o     <= 1'b1;
      width_o      <= decode_width(width_sel_i);
      big_endian_o <= big_endian_i;
    end
  end
endmodule

// File: rtl/rd_unpacker_ctrl.sv
module rd_unpacker_ctrl
  import rd_unpacker_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int LANES  = 4,
  localparam int CNT_W = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_ok_i,
  input  width_e            width_i,
  input  logic              rd_en_i,
  input  logic              fifo_empty_i,
  input  logic [WORD_W-1:0] fifo_data_i,
  output logic              fifo_pop_o,
  output logic [WORD_W-1:0] hold_o,
  output logic              valid_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] LAST_Q = CNT_W'(LANES - 1);

  logic [CNT_W-1:0] last_idx;
  logic take, fin, need;

  always_comb begin
    case (width_i)
      WIDTH_FULL: last_idx = '0;
      WIDTH_HALF: last_idx = CNT_W'(1);
      default:    last_idx = LAST_Q;
    endcase
  end

  assign take       = rd_en_i & valid_o;
  assign fin        = take & (cnt_o == last_idx);
  assign need       = ~valid_o | fin;
  assign fifo_pop_o = cfg_ok_i & need & ~fifo_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o  <= '0;
      valid_o <= 1'b0;
      cnt_o   <= '0;
    end else if (fifo_pop_o) begin
      hold_o  <= fifo_data_i;
      valid_o <= 1'b1;
      cnt_o   <= '0;
    end else if (fin) begin
      valid_o <= 1'b0;
      cnt_o   <= '0;
    end else if (take) begin
      cnt_o   <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/rd_unpacker_sel.sv
module rd_unpacker_sel
  import rd_unpacker_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int LANES  = 4,
  localparam int CNT_W  = $clog2(LANES),
  localparam int LANE_W = WORD_W / LANES,
  localparam int HALF_W = WORD_W / 2
) (
  input  logic [WORD_W-1:0] hold_i,
  input  logic              valid_i,
  input  width_e            width_i,
  input  logic              big_endian_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [WORD_W-1:0] data_o
);
  logic [LANE_W-1:0] lane [LANES];
  logic [HALF_W-1:0] half [2];
  logic [CNT_W-1:0]  q_idx;
  logic              h_idx;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane[i] = hold_i[i*LANE_W +: LANE_W];
  end
  for (genvar j = 0; j < 2; j++) begin : g_half
    assign half[j] = hold_i[j*HALF_W +: HALF_W];
  end

  // big-endian counts down from the top piece
  assign q_idx = big_endian_i ? (CNT_W'(LANES - 1) - cnt_i) : cnt_i;
  assign h_idx = big_endian_i ? ~cnt_i[0] : cnt_i[0];

  always_comb begin
    data_o = '0;
    if (valid_i) begin
      case (width_i)
        WIDTH_FULL: data_o = hold_i;
        WIDTH_HALF: data_o[HALF_W-1:0] = half[h_idx];
        default:    data_o[LANE_W-1:0] = lane[q_idx];
      endcase
    end
  end
endmodule

// File: rtl/rd_unpacker.sv
module rd_unpacker
  import rd_unpacker_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        width_sel_i,
  input  logic              big_endian_i,
  input  logic [WORD_W-1:0] fifo_data_i,
  input  logic              fifo_empty_i,
  output logic              fifo_pop_o,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  localparam int CNT_W = $clog2(LANES);

  logic              cfg_ok;
  width_e            cfg_width;
  logic              cfg_be;
  logic [WORD_W-1:0] hold;
  logic [CNT_W-1:0]  cnt;

  rd_unpacker_cfg u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .width_sel_i  (width_sel_i),
    .big_endian_i (big_endian_i),
    .cfg_ok_o     (cfg_ok),
    .width_o      (cfg_width),
    .big_endian_o (cfg_be)
  );

  rd_unpacker_ctrl #(.WORD_W(WORD_W), .LANES(LANES)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_ok_i     (cfg_ok),
    .width_i      (cfg_width),
    .rd_en_i      (rd_en_i),
    .fifo_empty_i (fifo_empty_i),
    .fifo_data_i  (fifo_data_i),
    .fifo_pop_o   (fifo_pop_o),
    .hold_o       (hold),
    .valid_o      (rd_valid_o),
    .cnt_o        (cnt)
  );

  rd_unpacker_sel #(.WORD_W(WORD_W), .LANES(LANES)) u_sel (
    .hold_i       (hold),
    .valid_i      (rd_valid_o),
    .width_i      (cfg_width),
    .big_endian_i (cfg_be),
    .cnt_i        (cnt),
    .data_o       (rd_data_o)
  );
endmodule

// File: rtl/rd_unpacker_chk.sv
module rd_unpacker_chk
  import rd_unpacker_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int LANES  = 4,
  localparam int LANE_W = WORD_W / LANES,
  localparam int HALF_W = WORD_W / 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_en_i,
  input logic              fifo_empty_i,
  input logic              fifo_pop_o,
  input logic              rd_valid_o,
  input logic [WORD_W-1:0] rd_data_o,
  input logic              cfg_ok,
  input width_e            cfg_width
);
  p_idle_before_cfg_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_ok |-> !fifo_pop_o && !rd_valid_o);

  p_cfg_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_ok |=> cfg_ok && $stable(cfg_width));

  p_half_upper_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_width == WIDTH_HALF |-> rd_data_o[WORD_W-1:HALF_W] == '0);

  p_quarter_upper_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_width == WIDTH_QUARTER |-> rd_data_o[WORD_W-1:LANE_W] == '0);

  p_no_pop_when_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> !fifo_empty_i);

  p_valid_after_pop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |=> rd_valid_o);

  p_hold_piece_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_en_i |=> rd_valid_o && $stable(rd_data_o));

  p_no_pop_unread_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_en_i |-> !fifo_pop_o);

  p_idle_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> rd_data_o == '0);
endmodule

bind rd_unpacker rd_unpacker_chk #(.WORD_W(WORD_W), .LANES(LANES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_en_i      (rd_en_i),
  .fifo_empty_i (fifo_empty_i),
  .fifo_pop_o   (fifo_pop_o),
  .rd_valid_o   (rd_valid_o),
  .rd_data_o    (rd_data_o),
  .cfg_ok       (cfg_ok),
  .cfg_width    (cfg_width)
);

// File: tb/rd_unpacker_test.sv
module rd_unpacker_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  width_sel_i = 2'b00;
  logic        big_endian_i = 1'b0;
  logic [35:0] fifo_data_i = '0;
  logic        fifo_empty_i = 1'b1;
  logic        fifo_pop_o;
  logic        rd_en_i = 1'b0;
  logic [35:0] rd_data_o;
  logic        rd_valid_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [35:0] fifo_q[$];
  logic [35:0] ref_q[$];

  always #4 clk_i = ~clk_i;

  rd_unpacker uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .width_sel_i(width_sel_i),
    .big_endian_i(big_endian_i), .fifo_data_i(fifo_data_i),
    .fifo_empty_i(fifo_empty_i), .fifo_pop_o(fifo_pop_o),
    .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
  );

  // show-ahead FIFO model
  always @(posedge clk_i) begin
    if (fifo_pop_o && fifo_q.size() > 0) void'(fifo_q.pop_front());
    fifo_data_i  <= (fifo_q.size() > 0) ? fifo_q[0] : '0;
    fifo_empty_i <= (fifo_q.size() == 0);
  end

  function automatic int pieces(logic [1:0] ws);
    return (ws == 2'b00) ? 1 : (ws == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic [35:0] exp_piece(logic [35:0] w, int idx, logic [1:0] ws, logic be);
    int n = pieces(ws);
    int p = be ? (n - 1 - idx) : idx;
    if (n == 1) return w;
    if (n == 2) return {18'b0, w[p*18 +: 18]};
    return {27'b0, w[p*9 +: 9]};
  endfunction

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_word(logic [35:0] w);
    fifo_q.push_back(w);
    ref_q.push_back(w);
    fifo_data_i  = fifo_q[0];
    fifo_empty_i = 1'b0;
  endtask

  function automatic logic [35:0] rnd_word();
    return {4'($urandom), 32'($urandom)};
  endfunction

  task automatic do_reset(logic [1:0] ws, logic be);
    @(negedge clk_i);
    rst_ni = 1'b0;
    rd_en_i = 1'b0;
    width_sel_i = ws;
    big_endian_i = be;
    fifo_q.delete();
    ref_q.delete();
    fifo_data_i = '0;
    fifo_empty_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 valid in reset", 36'(rd_valid_o), 36'd0);
    rst_ni = 1'b1;
  endtask

  function automatic string mode_tag(logic [1:0] ws, logic be);
    if (ws == 2'b00) return "R3 full";
    if (ws == 2'b01) return be ? "R4/R6 half" : "R4/R7 half";
    return be ? "R5/R6 byte" : "R5/R7 byte";
  endfunction

  task automatic run_random(logic [1:0] ws, logic be, int cycles);
    int idx = 0;
    int n = pieces(ws);
    string tag = mode_tag(ws, be);
    do_reset(ws, be);
    for (int c = 0; c < cycles + 200; c++) begin
      @(negedge clk_i);
      if (rd_valid_o) begin
        if (ref_q.size() == 0) chk({tag, " R8 extra word"}, 36'd1, 36'd0);
        else chk(tag, rd_data_o, exp_piece(ref_q[0], idx, ws, be));
      end else begin
        chk("R12 idle data", rd_data_o, '0);
      end
      if (c > 2 && $urandom_range(0, 15) == 0) begin
        width_sel_i = 2'($urandom);     // R2: must be ignored
        big_endian_i = 1'($urandom);
      end
      rd_en_i = (c >= cycles) ? 1'b1 : ($urandom_range(0, 2) != 0);
      if (rd_en_i && rd_valid_o && ref_q.size() > 0) begin
        idx++;
        if (idx == n) begin
          void'(ref_q.pop_front());
          idx = 0;
        end
      end
      if (c < cycles && fifo_q.size() < 12 && $urandom_range(0, 2) == 0)
        push_word(rnd_word());
    end
    rd_en_i = 1'b0;
    chk("R2/R8 all words delivered", 36'(ref_q.size()), 36'd0);
  endtask

  initial begin
    logic [35:0] w;
    void'($urandom(32'd20240611));
    // R1: prefilled FIFO at release, first cycle is capture only
    @(negedge clk_i);
    rst_ni = 1'b0;
    width_sel_i = 2'b01;
    big_endian_i = 1'b1;
    @(negedge clk_i);
    chk("R1 reset data", rd_data_o, '0);
    chk("R1 reset pop", 36'(fifo_pop_o), 36'd0);
    w = 36'h9_1234_5678;
    push_word(w);
    rst_ni = 1'b1;
    #1;
    chk("R1 pop in capture cycle", 36'(fifo_pop_o), 36'd0);
    chk("R1 valid in capture cycle", 36'(rd_valid_o), 36'd0);
    @(negedge clk_i);
    chk("R8 pop after capture", 36'(fifo_pop_o), 36'd1);
    chk("R12 data before valid", rd_data_o, '0);
    @(negedge clk_i);
    chk("R8 valid after pop", 36'(rd_valid_o), 36'd1);
    chk("R6 first half", rd_data_o, {18'b0, w[35:18]});

    // R10 and R9: byte mode, big-endian
    do_reset(2'b10, 1'b1);
    rd_en_i = 1'b1;
    repeat (5) begin
      @(negedge clk_i);
      chk("R10 no valid while empty", 36'(rd_valid_o), 36'd0);
    end
    rd_en_i = 1'b0;
    w = 36'hA_BCDE_F012;
    push_word(w);
    repeat (2) @(negedge clk_i);
    chk("R10 first piece after idle reads", rd_data_o, {27'b0, w[35:27]});
    rd_en_i = 1'b1;
    @(negedge clk_i);
    chk("R6 second byte", rd_data_o, {27'b0, w[26:18]});
    @(negedge clk_i);
    rd_en_i = 1'b0;
    repeat (6) @(negedge clk_i);
    chk("R9 partial valid", 36'(rd_valid_o), 36'd1);
    chk("R9 partial piece", rd_data_o, {27'b0, w[17:9]});
    rd_en_i = 1'b1;
    @(negedge clk_i);
    chk("R6 last byte", rd_data_o, {27'b0, w[8:0]});
    @(negedge clk_i);
    rd_en_i = 1'b0;
    chk("R8 word ends on last byte", 36'(rd_valid_o), 36'd0);

    // R11: back-to-back full words
    do_reset(2'b00, 1'b0);
    for (int i = 0; i < 3; i++) push_word(36'h1_0000_0000 * (i + 1) + 36'h55);
    repeat (3) @(negedge clk_i);
    rd_en_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      chk("R11 no bubble", 36'(rd_valid_o), 36'd1);
      chk("R3/R11 word order", rd_data_o, ref_q[0]);
      void'(ref_q.pop_front());
      @(negedge clk_i);
    end
    rd_en_i = 1'b0;
    chk("R3 drained", 36'(rd_valid_o), 36'd0);

    // random runs over every width code and endian setting
    for (int m = 0; m < 8; m++) run_random(2'(m >> 1), 1'(m), 2500);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule